// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block gathers up to 32 level-sensitive interrupt request lines and presents them to a primary interrupt controller in two ways. Each line's current level is captured into a raw level vector. An enable mask gates that vector, and the OR of every enabled, active line drives a single summary request on a fixed output line. A separate passthrough enable vector lets a contiguous band of lines drive their own output line directly, so the primary controller sees them without going through the summary.

Software reaches the block through a word-indexed register port with no wait states. The mask and the passthrough vector are never written directly. Each has a set register and a clear register, so a write changes only the bits it names. A small pair of indices works on bit 0 alone, as a software-triggered request. All outputs are registered. An output moves on the clock edge that captures the input change or the register write that causes it.

Top module: `sic_passthru`

## Requirements
- R1: After reset the raw level, the enable mask and the passthrough vector are all zero, every output line is low, and reads of index 0, 1, 2 and 8 return zero.
- R2: A read of index 1 returns the raw level vector. Each bit equals its input line as sampled on the most recent clock edge.
- R3: A write to index 2 ORs the write data into the enable mask. A read of index 2 returns the mask.
- R4: A write to index 3 clears every mask bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A read of index 0 returns the raw level ANDed with the enable mask.
- R6: A read of index 4 returns raw level bit 0 in bit 0, with all other bits zero. A nonzero write to index 4 sets mask bit 0. A nonzero write to index 5 clears mask bit 0. A zero write to either index changes nothing.
- R7: Output line 31 is high exactly when the value read at index 0 is nonzero. It updates on the same edge as the raw level and the mask.
- R8: A write to index 8 sets the passthrough bits named by the write data, but only within bits 21 to 30. A write to index 9 clears the named bits. A read of index 8 returns the vector, with bits 0 to 20 and bit 31 always zero. On the edge of either write, every enabled passthrough output is reloaded from its current input.
- R9: While its passthrough bit is set, output line n (21 to 30) takes the level of input n on each clock edge.
- R10: While its passthrough bit is clear, output line n (21 to 30) holds the last value it was driven with.
- R11: Reads of indices 6, 7 and 10 to 15 return zero. Writes to indices 0, 1, 6, 7 and 10 to 15 change no state and no output.
- R12: Output lines 0 to 20 are always low, whatever the inputs, the mask or the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request levels, one per line |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 4 | Register word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_idx; zero when not reading |
| irq_out | output | 32 | Lines toward the primary controller; line 31 is the summary |

## Verification
The bench builds the block with its default parameters: 32 lines, a passthrough band from line 21 to line 30, and the summary on line 31. With these values the band edges fall next to lines the band must never touch. Inputs driven high on lines 0 to 20 and a set-all write to the passthrough vector therefore show that the clamp and the fixed-low lines hold. The stimulus table walks one continuous register history. This shows that a line whose passthrough bit is cleared keeps a stale high, and that re-enabling it reloads it from the current input in the same cycle as the write.

// File: rtl/sic_pkg.sv
package sic_pkg;
   localparam int IDX_W = 4;

   localparam logic [IDX_W-1:0] IDX_STATUS = 4'd0;
   localparam logic [IDX_W-1:0] IDX_RAW    = 4'd1;
   localparam logic [IDX_W-1:0] IDX_MSET   = 4'd2;
   localparam logic [IDX_W-1:0] IDX_MCLR   = 4'd3;
   localparam logic [IDX_W-1:0] IDX_SWSET  = 4'd4;
   localparam logic [IDX_W-1:0] IDX_SWCLR  = 4'd5;
   localparam logic [IDX_W-1:0] IDX_PSET   = 4'd8;
   localparam logic [IDX_W-1:0] IDX_PCLR   = 4'd9;
endpackage

// File: rtl/sic_level.sv
module sic_level #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   output logic [N-1:0] level_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= irq_in;
   end
endmodule

// File: rtl/sic_regfile.sv
module sic_regfile
   import sic_pkg::*;
#(
   parameter int N     = 32,
   parameter int PT_LO = 21,
   parameter int PT_HI = 30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic               wr,
   input  logic [IDX_W-1:0]   idx,
   input  logic [N-1:0]       wdata,
   input  logic [N-1:0]       level_q,
   output logic [N-1:0]       mask_nxt,
   output logic [PT_HI-PT_LO:0] pt_nxt,
   output logic [N-1:0]       rdata
);
   localparam int PT_W = PT_HI - PT_LO + 1;

   logic [N-1:0]    mask_q;
   logic [PT_W-1:0] pt_q;
   logic            we;
   logic            wr_known;

   assign we = sel && wr;
   assign wr_known = idx inside {IDX_MSET, IDX_MCLR, IDX_SWSET, IDX_SWCLR, IDX_PSET, IDX_PCLR};

   always_comb begin
      mask_nxt = mask_q;
      pt_nxt   = pt_q;
      if (we) begin
         case (idx)
            IDX_MSET:  mask_nxt = mask_q | wdata;
            IDX_MCLR:  mask_nxt = mask_q & ~wdata;
            IDX_SWSET: if (|wdata) mask_nxt[0] = 1'b1;
            IDX_SWCLR: if (|wdata) mask_nxt[0] = 1'b0;
            IDX_PSET:  pt_nxt = pt_q | wdata[PT_HI:PT_LO];
            IDX_PCLR:  pt_nxt = pt_q & ~wdata[PT_HI:PT_LO];
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         pt_q   <= '0;
      end else begin
         mask_q <= mask_nxt;
         pt_q   <= pt_nxt;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel && !wr) begin
         case (idx)
            IDX_STATUS: rdata = level_q & mask_q;
            IDX_RAW:    rdata = level_q;
            IDX_MSET:   rdata = mask_q;
            IDX_SWSET:  rdata = N'(level_q[0]);
            IDX_PSET:   rdata = N'(pt_q) << PT_LO;
            default:    rdata = '0;
         endcase
      end
   end

   // R3
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IDX_MSET) |=> ((mask_q & $past(wdata)) == $past(wdata)));

   // R4
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IDX_MCLR) |=> ((mask_q & $past(wdata)) == '0));

   // R8
   pt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IDX_PSET) |=> ((pt_q & $past(wdata[PT_HI:PT_LO])) == $past(wdata[PT_HI:PT_LO])));

   // R11
   undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wr_known) |=> ($stable(mask_q) && $stable(pt_q)));

   // R6
   sw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (idx == IDX_SWSET || idx == IDX_SWCLR) && wdata == '0) |=> $stable(mask_q));
endmodule

// File: rtl/sic_outstage.sv
module sic_outstage #(
   parameter int N        = 32,
   parameter int PT_LO    = 21,
   parameter int PT_HI    = 30,
   parameter int SUM_LINE = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         irq_in,
   input  logic [N-1:0]         mask_nxt,
   input  logic [PT_HI-PT_LO:0] pt_nxt,
   output logic [N-1:0]         irq_out
);
   for (genvar i = 0; i < N; i++) begin : g_line
      if (i == SUM_LINE) begin : g_sum
         logic sum_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sum_q <= 1'b0;
            else        sum_q <= |(irq_in & mask_nxt);
         end
         assign irq_out[i] = sum_q;
      end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
         logic pass_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pass_q <= 1'b0;
            else if (pt_nxt[i-PT_LO])  pass_q <= irq_in[i];
         end
         assign irq_out[i] = pass_q;

         // R9
         pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pt_nxt[i-PT_LO] |=> (irq_out[i] == $past(irq_in[i])));

         // R10
         pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pt_nxt[i-PT_LO] |=> $stable(irq_out[i]));
      end else begin : g_off
         assign irq_out[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sic_passthru.sv
module sic_passthru
   import sic_pkg::*;
#(
   parameter int N        = 32,
   parameter int PT_LO    = 21,
   parameter int PT_HI    = 30,
   parameter int SUM_LINE = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     irq_in,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [IDX_W-1:0] bus_idx,
   input  logic [N-1:0]     bus_wdata,
   output logic [N-1:0]     bus_rdata,
   output logic [N-1:0]     irq_out
);
   if (N < 2 || N > 32) begin : g_bad_n
      $error("sic_passthru: N must be 2..32");
   end
   if (PT_LO < 0 || PT_LO > PT_HI || PT_HI >= N) begin : g_bad_band
      $error("sic_passthru: passthrough band out of range");
   end
   if (SUM_LINE >= N || (SUM_LINE >= PT_LO && SUM_LINE <= PT_HI)) begin : g_bad_sum
      $error("sic_passthru: summary line must lie outside the band");
   end

   logic [N-1:0]         level_q;
   logic [N-1:0]         mask_nxt;
   logic [PT_HI-PT_LO:0] pt_nxt;

   sic_level #(.N(N)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .level_q (level_q)
   );

   sic_regfile #(.N(N), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bus_sel),
      .wr       (bus_wr),
      .idx      (bus_idx),
      .wdata    (bus_wdata),
      .level_q  (level_q),
      .mask_nxt (mask_nxt),
      .pt_nxt   (pt_nxt),
      .rdata    (bus_rdata)
   );

   sic_outstage #(.N(N), .PT_LO(PT_LO), .PT_HI(PT_HI), .SUM_LINE(SUM_LINE)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .mask_nxt (mask_nxt),
      .pt_nxt   (pt_nxt),
      .irq_out  (irq_out)
   );
endmodule

// File: tb/sic_passthru_tb.sv
module sic_passthru_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] irq_in;
   logic        bus_sel;
   logic        bus_wr;
   logic [3:0]  bus_idx;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [31:0] irq_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sic_passthru u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_idx   (bus_idx),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   // {req[7:0], in[31:0], wr, widx[3:0], wdata[31:0], ridx[3:0], exp_rd[31:0], exp_out[31:0]}
   localparam int NSTEP = 17;
   localparam logic [144:0] TBL [NSTEP] = '{
      // R2 raw level follows inputs
      {8'd2,  32'h000000F0, 1'b0, 4'd0, 32'h00000000, 4'd1, 32'h000000F0, 32'h00000000},
      // R5 R7 mask set, status and summary
      {8'd5,  32'h000000F0, 1'b1, 4'd2, 32'h00000030, 4'd0, 32'h00000030, 32'h80000000},
      // R4 mask clear
      {8'd4,  32'h000000F0, 1'b1, 4'd3, 32'h00000010, 4'd2, 32'h00000020, 32'h80000000},
      // R7 no enabled line active
      {8'd7,  32'h0000000F, 1'b0, 4'd0, 32'h00000000, 4'd0, 32'h00000000, 32'h00000000},
      // R6 soft set of bit 0
      {8'd6,  32'h0000000F, 1'b1, 4'd4, 32'h00000100, 4'd4, 32'h00000001, 32'h80000000},
      // R6 soft clear of bit 0
      {8'd6,  32'h0000000E, 1'b1, 4'd5, 32'h00000002, 4'd4, 32'h00000000, 32'h00000000},
      // R6 zero soft write ignored
      {8'd6,  32'h0000000E, 1'b1, 4'd4, 32'h00000000, 4'd2, 32'h00000020, 32'h00000000},
      // R8 passthrough set clamped to 21..30
      {8'd8,  32'h0000000E, 1'b1, 4'd8, 32'hFFFFFFFF, 4'd8, 32'h7FE00000, 32'h00000000},
      // R9 enabled lines follow
      {8'd9,  32'h40200020, 1'b0, 4'd0, 32'h00000000, 4'd1, 32'h40200020, 32'hC0200000},
      // R10 line 30 cleared, holds high
      {8'd10, 32'h40200000, 1'b1, 4'd9, 32'h40000000, 4'd8, 32'h3FE00000, 32'h40200000},
      // R10 line 30 still held, line 21 follows low
      {8'd10, 32'h00000000, 1'b0, 4'd0, 32'h00000000, 4'd1, 32'h00000000, 32'h40000000},
      // R11 undefined index write and read
      {8'd11, 32'h00000000, 1'b1, 4'd6, 32'hFFFFFFFF, 4'd6, 32'h00000000, 32'h40000000},
      // R11 write to status index ignored
      {8'd11, 32'h00000000, 1'b1, 4'd0, 32'hFFFFFFFF, 4'd2, 32'h00000020, 32'h40000000},
      // R12 lines 0..20 high stay low at the outputs
      {8'd12, 32'h001FFFFF, 1'b1, 4'd2, 32'h00000000, 4'd0, 32'h00000020, 32'hC0000000},
      // R8 re-enable reloads line 30 from input
      {8'd8,  32'h001FFFFF, 1'b1, 4'd8, 32'h40000000, 4'd8, 32'h7FE00000, 32'h80000000},
      // R8 clear all passthrough, outputs hold
      {8'd8,  32'h001FFFFF, 1'b1, 4'd9, 32'hFFFFFFFF, 4'd8, 32'h00000000, 32'h80000000},
      // R11 top index ignored
      {8'd11, 32'h001FFFFF, 1'b1, 4'd15, 32'hFFFFFFFF, 4'd15, 32'h00000000, 32'h80000000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] i);
      bus_sel = 1'b1;
      bus_wr  = 1'b0;
      bus_idx = i;
      #1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      rst_n = 1'b0; irq_in = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_idx = '0; bus_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      chk("R1 reset irq_out", irq_out, 32'h0);
      rd(4'd0); chk("R1 reset status", bus_rdata, 32'h0);
      rd(4'd1); chk("R1 reset raw", bus_rdata, 32'h0);
      rd(4'd2); chk("R1 reset mask", bus_rdata, 32'h0);
      rd(4'd8); chk("R1 reset passthrough", bus_rdata, 32'h0);

      for (int s = 0; s < NSTEP; s++) begin
         logic [144:0] e;
         e = TBL[s];
         @(negedge clk);
         irq_in    = e[136:105];
         bus_sel   = 1'b1;
         bus_wr    = e[104];
         bus_idx   = e[103:100];
         bus_wdata = e[99:68];
         @(posedge clk);
         #1;
         rd(e[67:64]);
         chk($sformatf("R%0d step %0d rdata", e[144:137], s), bus_rdata, e[63:32]);
         chk($sformatf("R%0d step %0d irq_out", e[144:137], s), irq_out, e[31:0]);
      end

      // R12 all inputs high with full passthrough: lines 0..20 stay low
      @(negedge clk);
      irq_in = 32'hFFFFFFFF; bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = 4'd8; bus_wdata = 32'hFFFFFFFF;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      chk("R12 low lines with all inputs high", irq_out & 32'h001FFFFF, 32'h0);
      chk("R9 band reloads on enable", irq_out & 32'h7FE00000, 32'h7FE00000);

      // R1 asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 mid-run reset irq_out", irq_out, 32'h0);
      rd(4'd2); chk("R1 mid-run reset mask", bus_rdata, 32'h0);
      rd(4'd8); chk("R1 mid-run reset passthrough", bus_rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      bus_sel = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule